// File: doc/BRIEF.md
# Dual-Rail Start Sequencer and Fault Supervisor

This block is the digital supervisor for a controller that drives two step-down rails, a 3.3 V rail and a 5 V rail. It takes comparator results that have already been digitised, together with a tick that marks each switching cycle. From these it decides which rail may switch, when the low-side switches must be forced on, and when the system power-good line may rise. A shutdown input and a 3.3 V enable input select the operating mode. A two-bit sequence selector chooses one of three start schemes. In independent start, each rail follows its own enable. In the two timed schemes, one rail starts on a rising edge of the 3.3 V enable, and the other rail waits until a timing-pin comparator reports that its level is above the reference.

Two tick counters set the timing. The first keeps power-good low for a fixed number of switching cycles after start-up. A separate counter for each rail arms the deep-undervoltage protection a set number of cycles after that rail is enabled. An overvoltage on either rail latches both rails off and holds both low-side switches on. A deep undervoltage after arming latches both rails off. A shallow dip does not latch anything; it only pulls power-good low. A latched fault stays in place until the shutdown input or the 3.3 V enable changes level, or until the global synchronous reset, which stands for loss of the input supply.

Top module: `rail_supervisor`

## Requirements
- R1: `mode` reads 2'b00 (off) whenever `shdn_n` is low. It reads 2'b10 (run) when `shdn_n` is high and at least one rail is requested. It reads 2'b01 (standby) when `shdn_n` is high and no rail is requested. The mode and the rail enables are registered and update one clock after their inputs change.
- R2: With `seq_sel` 2'b00 (independent; 2'b11 behaves the same), `run[0]` (3.3 V) follows `en3` and `run[1]` (5 V) follows `en5`, gated by `shdn_n`. `tpin_hi` is ignored in this mode.
- R3: In independent mode, `sys_ok` depends only on the 3.3 V rail, so flags on the 5 V rail have no effect on it. When only the 5 V rail is enabled, `sys_ok` stays low.
- R4: With `seq_sel` 2'b01, the 5 V rail starts on a rising edge of `en3` seen after reset. If `en3` is already high when this mode is selected, nothing starts. The 3.3 V rail starts once `tpin_hi` is high while the 5 V rail is requested. Both rails stop when `en3` goes low. `en5` is ignored in this mode.
- R5: With `seq_sel` 2'b10, the roles are swapped: the 3.3 V rail starts on the `en3` rising edge, and the 5 V rail starts on `tpin_hi`.
- R6: In the timed modes, `sys_ok` requires both rails to be running and both `inreg` bits to be high. It is low while `en3` is low.
- R7: `sys_ok` stays low until PG_TICKS ticks (default 32000) have been counted while at least one rail is requested. The count restarts when no rail is requested.
- R8: Each rail's undervoltage protection arms after UV_TICKS ticks (default 6144) counted while that rail is requested. The count restarts from zero when that rail is no longer requested.
- R9: Any `ov_flag` bit, while `shdn_n` is high, latches `run` to 2'b00 and `force_low` to 2'b11 from the next clock onward.
- R10: A `uv_flag` bit on an armed rail latches `run` to 2'b00, and `force_low` stays 2'b00. A `low_flag` bit on a monitored rail pulls `sys_ok` low on the next clock without latching, and `sys_ok` returns once the flag clears.
- R11: Latched faults clear only on a level change of `shdn_n` or `en3`, or on `rst`. A change of `en5` leaves them in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; stands for supply loss |
| tick | input | 1 | One-clock pulse per switching cycle |
| shdn_n | input | 1 | Shutdown control, low = shutdown |
| en3 | input | 1 | 3.3 V rail enable; start trigger in timed modes |
| en5 | input | 1 | 5 V rail enable in independent mode |
| tpin_hi | input | 1 | Timing-pin comparator: level above reference |
| seq_sel | input | 2 | 00/11 independent, 01 5 V first, 10 3.3 V first |
| ov_flag | input | 2 | Overvoltage comparator per rail (bit0 3.3 V, bit1 5 V) |
| uv_flag | input | 2 | Deep undervoltage (30 %) comparator per rail |
| low_flag | input | 2 | Shallow undervoltage (5 %) comparator per rail |
| inreg | input | 2 | In-regulation comparator per rail |
| run | output | 2 | Switching enable per rail |
| force_low | output | 2 | Force low-side switch on, per rail |
| mode | output | 2 | 00 off, 01 standby, 10 run |
| sys_ok | output | 1 | Power-good, high when the system may leave reset |

## Verification
The bench checks power-good on both sides of its release count. A counter that released early, or that never released, would show the wrong level at one of those two sample points. It selects a timed mode while `en3` is already high; a design that starts rails on the level of `en3` instead of its edge would start a rail there. It checks the latched faults after the causing flag has gone away, toggles `en5` to show that this does not clear them, and then toggles `shdn_n` and `en3` to show that these do. A design that cleared faults on any input change, or that did not latch at all, would recover too early. Finally, it raises the deep-undervoltage flag before and after arming; a rail armed from the start would be cut off in the early window.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_IDLE = 2'b01,
        MODE_RUN  = 2'b10
    } mode_e;

    typedef enum logic [1:0] {
        SEQ_IND         = 2'b00,
        SEQ_FIVE_FIRST  = 2'b01,
        SEQ_THREE_FIRST = 2'b10,
        SEQ_IND_ALT     = 2'b11
    } seq_e;

    localparam int RAILS = 2;
endpackage

// File: rtl/rs_tick_timer.sv
module rs_tick_timer #(
    parameter int LIMIT = 6144
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic tick,
    output logic done
);
    localparam int W = $clog2(LIMIT + 1);

    logic [W-1:0] cnt_d, cnt_q;

    assign done = (cnt_q == W'(LIMIT));

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (tick && !done)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // R8: disabling the rail restarts the count
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt_q == '0));
    // R7/R8: never counts past the limit
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= W'(LIMIT));
endmodule

// File: rtl/rs_seq.sv
module rs_seq
    import rs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shdn_n,
    input  logic             en3,
    input  logic             en5,
    input  logic             tpin_hi,
    input  seq_e             seq,
    output logic [RAILS-1:0] want,
    output mode_e            mode
);
    typedef struct packed {
        logic             en3_q;
        logic             first;
        logic             second;
        logic [RAILS-1:0] want;
        mode_e            mode;
    } seq_st_t;

    seq_st_t st_d, st_q;
    logic rise, first_go, second_go;

    always_comb begin
        st_d      = st_q;
        rise      = en3 & ~st_q.en3_q;
        first_go  = shdn_n & en3 & (st_q.first | rise);
        second_go = first_go & (st_q.second | tpin_hi);
        st_d.en3_q = en3;
        unique case (seq)
            SEQ_FIVE_FIRST: begin
                st_d.first  = first_go;
                st_d.second = second_go;
                st_d.want   = {first_go, second_go};
            end
            SEQ_THREE_FIRST: begin
                st_d.first  = first_go;
                st_d.second = second_go;
                st_d.want   = {second_go, first_go};
            end
            default: begin
                st_d.first  = 1'b0;
                st_d.second = 1'b0;
                st_d.want   = {en5, en3} & {RAILS{shdn_n}};
            end
        endcase
        if (!shdn_n)        st_d.mode = MODE_OFF;
        else if (|st_d.want) st_d.mode = MODE_RUN;
        else                st_d.mode = MODE_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.en3_q  <= 1'b0;
            st_q.first  <= 1'b0;
            st_q.second <= 1'b0;
            st_q.want   <= '0;
            st_q.mode   <= MODE_OFF;
        end else begin
            st_q <= st_d;
        end
    end

    assign want = st_q.want;
    assign mode = st_q.mode;

    // R4/R5: a timed second rail never runs without the first
    a_r4_order: assert property (@(posedge clk) disable iff (rst)
        st_q.second |-> st_q.first);
endmodule

// File: rtl/rs_fault.sv
module rs_fault
    import rs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             shdn_n,
    input  logic             en3,
    input  logic [RAILS-1:0] ov,
    input  logic [RAILS-1:0] uv,
    input  logic [RAILS-1:0] armed,
    output logic             ov_lat,
    output logic             uv_lat
);
    typedef struct packed {
        logic shdn_q;
        logic en3_q;
        logic ov;
        logic uv;
    } flt_st_t;

    flt_st_t st_d, st_q;
    logic toggle;

    always_comb begin
        toggle      = (shdn_n ^ st_q.shdn_q) | (en3 ^ st_q.en3_q);
        st_d.shdn_q = shdn_n;
        st_d.en3_q  = en3;
        st_d.ov     = shdn_n & ((st_q.ov & ~toggle) | (|ov));
        st_d.uv     = shdn_n & ((st_q.uv & ~toggle) | (|(uv & armed)));
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ov_lat = st_q.ov;
    assign uv_lat = st_q.uv;

    // R11: a latched overvoltage holds while no clearing input changes
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (st_q.ov && shdn_n && $stable(shdn_n) && $stable(en3)) |=> st_q.ov);
endmodule

// File: rtl/rail_supervisor.sv
module rail_supervisor
    import rs_pkg::*;
#(
    parameter int PG_TICKS = 32000,
    parameter int UV_TICKS = 6144
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       shdn_n,
    input  logic       en3,
    input  logic       en5,
    input  logic       tpin_hi,
    input  logic [1:0] seq_sel,
    input  logic [1:0] ov_flag,
    input  logic [1:0] uv_flag,
    input  logic [1:0] low_flag,
    input  logic [1:0] inreg,
    output logic [1:0] run,
    output logic [1:0] force_low,
    output logic [1:0] mode,
    output logic       sys_ok
);
    seq_e             seq;
    mode_e            mode_w;
    logic [RAILS-1:0] want_q;
    logic [RAILS-1:0] armed;
    logic             pg_done;
    logic             ov_lat, uv_lat;
    logic             ok_d, ok_q, cond;

    assign seq = seq_e'(seq_sel);

    rs_seq u_seq (
        .clk(clk), .rst(rst), .shdn_n(shdn_n), .en3(en3), .en5(en5),
        .tpin_hi(tpin_hi), .seq(seq), .want(want_q), .mode(mode_w)
    );

    genvar g;
    generate
        for (g = 0; g < RAILS; g++) begin : g_uv_arm
            rs_tick_timer #(.LIMIT(UV_TICKS)) u_arm (
                .clk(clk), .rst(rst), .clear(~want_q[g]), .tick(tick),
                .done(armed[g])
            );
        end
    endgenerate

    rs_tick_timer #(.LIMIT(PG_TICKS)) u_pg (
        .clk(clk), .rst(rst), .clear(~(|want_q)), .tick(tick), .done(pg_done)
    );

    rs_fault u_fault (
        .clk(clk), .rst(rst), .shdn_n(shdn_n), .en3(en3), .ov(ov_flag),
        .uv(uv_flag), .armed(armed), .ov_lat(ov_lat), .uv_lat(uv_lat)
    );

    always_comb begin
        unique case (seq)
            SEQ_FIVE_FIRST, SEQ_THREE_FIRST:
                cond = en3 & (&want_q) & (&inreg) & ~(|low_flag);
            default:
                cond = want_q[0] & inreg[0] & ~low_flag[0];
        endcase
        ok_d = shdn_n & pg_done & ~ov_lat & ~uv_lat & cond;
    end

    always_ff @(posedge clk) begin
        if (rst) ok_q <= 1'b0;
        else     ok_q <= ok_d;
    end

    assign run       = want_q & ~{RAILS{ov_lat | uv_lat}};
    assign force_low = {RAILS{ov_lat}};
    assign mode      = mode_w;
    assign sys_ok    = ok_q;

    // R1: shutdown stops both rails on the next clock
    a_r1_shut_off: assert property (@(posedge clk) disable iff (rst)
        !shdn_n |=> (run == 2'b00));
    // R9: overvoltage latches rails off and low sides on
    a_r9_ov_latch: assert property (@(posedge clk) disable iff (rst)
        (shdn_n && |ov_flag) |=> (force_low == 2'b11 && run == 2'b00));
    // R10: a shallow dip on the 3.3 V rail drops power-good
    a_r10_low_drop: assert property (@(posedge clk) disable iff (rst)
        (shdn_n && low_flag[0]) |=> !sys_ok);
    // R7: power-good waits for the release count
    a_r7_ok_timer: assert property (@(posedge clk) disable iff (rst)
        !pg_done |=> !sys_ok);
endmodule

// File: tb/rail_supervisor_test.sv
module rail_supervisor_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b1;
    logic shdn_n = 1'b0, en3 = 1'b0, en5 = 1'b0, tpin_hi = 1'b0;
    logic [1:0] seq_sel = 2'b00, ov_flag = 2'b00, uv_flag = 2'b00;
    logic [1:0] low_flag = 2'b00, inreg = 2'b00;
    logic [1:0] run, force_low, mode;
    logic       sys_ok;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rail_supervisor #(.PG_TICKS(40), .UV_TICKS(20)) uut (
        .clk(clk), .rst(rst), .tick(tick), .shdn_n(shdn_n), .en3(en3),
        .en5(en5), .tpin_hi(tpin_hi), .seq_sel(seq_sel), .ov_flag(ov_flag),
        .uv_flag(uv_flag), .low_flag(low_flag), .inreg(inreg), .run(run),
        .force_low(force_low), .mode(mode), .sys_ok(sys_ok)
    );

    // {shdn_n, en3, en5, seq_sel[1:0], mode[1:0], run[1:0]}
    localparam logic [8:0] VEC [8] = '{
        9'b0_11_00_00_00,  // R1 shutdown overrides enables
        9'b1_00_00_01_00,  // R1 standby
        9'b1_10_00_10_01,  // R2 3.3 V only
        9'b1_01_00_10_10,  // R2 5 V only
        9'b1_11_00_10_11,  // R2 both
        9'b0_11_11_00_00,  // R1 shutdown, alt code
        9'b1_11_11_10_11,  // R2 code 11 acts independent
        9'b1_01_01_01_00   // R4 en5 ignored in timed mode
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic s, input logic e3, input logic e5, input logic [1:0] sq);
        @(negedge clk);
        rst = 1'b1;
        shdn_n = s; en3 = e3; en5 = e5; seq_sel = sq; tpin_hi = 1'b0;
        ov_flag = 2'b00; uv_flag = 2'b00; low_flag = 2'b00; inreg = 2'b00;
        step(2);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // reset state
        step(3);
        check("R1 reset mode", {6'd0, mode}, 8'h00);
        check("R9 reset force_low", {6'd0, force_low}, 8'h00);
        check("R7 reset sys_ok", {7'd0, sys_ok}, 8'h00);
        rst = 1'b0;

        // mode decode table
        for (int i = 0; i < 8; i++) begin
            {shdn_n, en3, en5, seq_sel} = VEC[i][8:4];
            step(2);
            check($sformatf("R1 vec%0d mode", i), {6'd0, mode}, {6'd0, VEC[i][3:2]});
            check($sformatf("R2 vec%0d run", i), {6'd0, run}, {6'd0, VEC[i][1:0]});
        end

        // R7 / R3: independent power-good
        do_reset(1'b1, 1'b1, 1'b1, 2'b00);
        inreg = 2'b11;
        step(30);
        check("R7 ok held early", {7'd0, sys_ok}, 8'h00);
        step(25);
        check("R7 ok released", {7'd0, sys_ok}, 8'h01);
        low_flag = 2'b10; inreg = 2'b01;
        step(2);
        check("R3 5V flags ignored", {7'd0, sys_ok}, 8'h01);
        low_flag = 2'b01;
        step(2);
        check("R10 shallow dip drops ok", {7'd0, sys_ok}, 8'h00);
        low_flag = 2'b00;
        step(2);
        check("R10 dip not latched", {7'd0, sys_ok}, 8'h01);

        // R3: only 5 V enabled
        do_reset(1'b1, 1'b0, 1'b1, 2'b00);
        inreg = 2'b11;
        step(60);
        check("R3 5V only keeps ok low", {7'd0, sys_ok}, 8'h00);

        // R8 / R10 / R11: undervoltage arming and latch
        do_reset(1'b1, 1'b1, 1'b0, 2'b00);
        uv_flag = 2'b01;
        step(10);
        check("R8 not armed yet", {6'd0, run}, 8'h01);
        step(20);
        check("R10 uv latched off", {6'd0, run}, 8'h00);
        check("R10 uv no force", {6'd0, force_low}, 8'h00);
        uv_flag = 2'b00;
        step(3);
        check("R11 uv stays latched", {6'd0, run}, 8'h00);
        en3 = 1'b0;
        step(2);
        en3 = 1'b1;
        step(3);
        check("R11 en3 toggle clears", {6'd0, run}, 8'h01);

        // R9 / R11: overvoltage latch
        do_reset(1'b1, 1'b1, 1'b1, 2'b00);
        step(2);
        ov_flag = 2'b10;
        step(1);
        ov_flag = 2'b00;
        step(2);
        check("R9 ov force_low", {6'd0, force_low}, 8'h03);
        check("R9 ov run off", {6'd0, run}, 8'h00);
        en5 = 1'b0;
        step(2);
        en5 = 1'b1;
        step(2);
        check("R11 en5 toggle keeps latch", {6'd0, force_low}, 8'h03);
        shdn_n = 1'b0;
        step(2);
        shdn_n = 1'b1;
        step(2);
        check("R11 shdn toggle clears force", {6'd0, force_low}, 8'h00);
        check("R11 shdn toggle restores run", {6'd0, run}, 8'h03);
        ov_flag = 2'b01;
        step(1);
        ov_flag = 2'b00;
        rst = 1'b1;
        step(2);
        rst = 1'b0;
        step(1);
        check("R11 reset clears latch", {6'd0, force_low}, 8'h00);

        // R4 / R6: 5 V first
        do_reset(1'b1, 1'b0, 1'b0, 2'b01);
        inreg = 2'b11;
        step(2);
        en3 = 1'b1;
        step(2);
        check("R4 5V starts on en3 edge", {6'd0, run}, 8'h02);
        step(3);
        check("R4 3V waits for tpin", {6'd0, run}, 8'h02);
        tpin_hi = 1'b1;
        step(2);
        check("R4 3V starts on tpin", {6'd0, run}, 8'h03);
        step(60);
        check("R6 ok with both in regulation", {7'd0, sys_ok}, 8'h01);
        inreg = 2'b01;
        step(2);
        check("R6 ok needs 5V in regulation", {7'd0, sys_ok}, 8'h00);
        inreg = 2'b11;
        en3 = 1'b0;
        step(2);
        check("R4 en3 low stops rails", {6'd0, run}, 8'h00);
        check("R6 ok low with en3 low", {7'd0, sys_ok}, 8'h00);

        // R5: 3.3 V first
        do_reset(1'b1, 1'b0, 1'b0, 2'b10);
        step(2);
        en3 = 1'b1;
        step(2);
        check("R5 3V starts on en3 edge", {6'd0, run}, 8'h01);
        tpin_hi = 1'b1;
        step(2);
        check("R5 5V starts on tpin", {6'd0, run}, 8'h03);

        // R4: level without edge starts nothing
        do_reset(1'b1, 1'b1, 1'b0, 2'b00);
        step(3);
        seq_sel = 2'b01;
        tpin_hi = 1'b1;
        step(3);
        check("R4 no start without edge", {6'd0, run}, 8'h00);
        check("R1 standby without start", {6'd0, mode}, 8'h01);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule